// File: doc/BRIEF.md
# PLL Configuration Register and Lock Timer

This block keeps the configuration word of one PLL and decides when that PLL counts as locked. It does not look at a phase detector. Every register write restarts a countdown that runs on a slow-clock tick. The lock flag rises when that countdown runs out. Software sets a divide factor, a lock count, an output-range code and a multiply factor with one 32-bit write. It can read back either the stored word or a status word.

From the stored fields the block decodes the following:
- whether the PLL is running at all;
- the effective divide factor, including the two special divider codes (zero output and bypass);
- the effective multiply factor.

A sticky error flag records any write that leaves the mandatory marker bit clear. The slow clock comes in as a single-cycle tick in the system clock domain.

Top module: `pllcfg_top`

## Requirements
- R1: A write (wr_en high) stores its fields, and with rd_sel=0 rd_data returns them in this layout: divider in bits 7..0, lock count in bits 13..8, range code in bits 15..14, multiplier in bits 26..16, marker in bit 29 as written, and all other bits 0. With rd_sel=1, rd_data returns lock in bit 0, the error flag in bit 1 and active in bit 2, with all other bits 0.
- R2: div_ratio equals the divider field. div_zero is 1 exactly when the field is 0 (the output is held at zero). div_bypass is 1 exactly when the field is 1.
- R3: pll_active is 1 exactly when the multiplier field is nonzero. mul_ratio equals the field plus 1 when the PLL is active, and 0 when it is not.
- R4: For a lock count N of 1 or more, with the PLL active and the divider nonzero, pll_lock is 0 through the first N-1 slow ticks after a write. It reads 1 in the cycle after the Nth tick is sampled.
- R5: A lock count of 0 sets pll_lock on the first slow tick after the write.
- R6: Any write, even one that repeats the stored value, clears pll_lock in the next cycle and restarts the countdown from the new lock count.
- R7: While the multiplier field or the divider field is 0, pll_lock stays 0 whatever the number of slow ticks.
- R8: A write with bit 29 clear sets cfg_err from the next cycle on. Later writes do not clear it; only reset clears it.
- R9: After reset the stored word is all zeros, and pll_lock, cfg_err and pll_active are 0.
- R10: Once set, pll_lock stays 1 through further slow ticks until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to store |
| rd_sel | input | 1 | 0 selects the configuration word, 1 selects the status word |
| rd_data | output | 32 | Read data, combinational from the selection |
| pll_lock | output | 1 | Lock flag |
| pll_active | output | 1 | Multiplier is nonzero |
| div_zero | output | 1 | Divider code 0 (output held at zero) |
| div_bypass | output | 1 | Divider code 1 (divider bypassed) |
| div_ratio | output | 8 | Effective divide factor |
| mul_ratio | output | 12 | Effective multiply factor, 0 when inactive |
| cfg_err | output | 1 | Sticky marker-bit error |

## Verification
The timing of each result is as follows:
- The stored word and the decoded ratios appear one clock edge after the write.
- The error flag also appears one edge after the write.
- The lock flag clears one edge after any write.
- The lock flag rises one edge after the slow tick that completes the count.

Inputs are driven at the falling edge and held for exactly one cycle. Every check is made at the falling edge that follows the edge where the result is due. Lock checks are made after each individual tick, so an early or late rise shows up at the exact tick count.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;
    localparam int WORD_W  = 32;
    localparam int DIV_W   = 8;
    localparam int CNT_W   = 6;
    localparam int RNG_W   = 2;
    localparam int MUL_W   = 11;
    localparam int DIV_LSB = 0;
    localparam int CNT_LSB = DIV_LSB + DIV_W;
    localparam int RNG_LSB = CNT_LSB + CNT_W;
    localparam int MUL_LSB = RNG_LSB + RNG_W;
    localparam int MRK_BIT = 29;
    localparam int RAT_W   = MUL_W + 1;

    typedef struct packed {
        logic [MUL_W-1:0] mul;
        logic [RNG_W-1:0] rng;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic             mrk;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic err;
    } reg_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic             lock;
    } tmr_state_t;
endpackage

// File: rtl/pllcfg_ratio_dec.sv
module pllcfg_ratio_dec #(
    parameter int DIV_W = 8,
    parameter int MUL_W = 11,
    localparam int RAT_W = MUL_W + 1
) (
    input  logic [DIV_W-1:0] div_f,
    input  logic [MUL_W-1:0] mul_f,
    output logic [DIV_W-1:0] div_ratio,
    output logic [RAT_W-1:0] mul_ratio,
    output logic             active,
    output logic             div_zero,
    output logic             div_bypass
);
    always_comb begin
        active     = (mul_f != '0);
        div_zero   = (div_f == '0);
        div_bypass = (div_f == DIV_W'(1));
        div_ratio  = div_f;
        mul_ratio  = active ? ({1'b0, mul_f} + RAT_W'(1)) : '0;
    end

    always_comb begin
        if (div_zero) assert (div_ratio == '0) else $error("a_r2_zero_ratio");
        if (!active)  assert (mul_ratio == '0) else $error("a_r3_idle_ratio");
    end
endmodule

// File: rtl/pllcfg_lock_timer.sv
module pllcfg_lock_timer
    import pllcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             restart,
    input  logic             run_ok,
    input  logic [CNT_W-1:0] load_val,
    output logic             lock
);
    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.lock = 1'b0;
            st_d.pend = 1'b1;
            st_d.cnt  = '0;
        end else if (!run_ok) begin
            st_d.lock = 1'b0;
            st_d.pend = 1'b0;
            st_d.cnt  = '0;
        end else if (slow_tick) begin
            if (st_q.pend) begin
                st_d.pend = 1'b0;
                if (load_val <= CNT_W'(1)) st_d.lock = 1'b1;
                else                       st_d.cnt  = load_val - CNT_W'(1);
            end else if (!st_q.lock && st_q.cnt != '0) begin
                if (st_q.cnt == CNT_W'(1)) begin
                    st_d.lock = 1'b1;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock = st_q.lock;

    a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !lock);
    a_r7_idle_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_ok && !restart) |=> !lock);
    a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && !slow_tick) |=> !lock);
    a_r10_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && run_ok && !restart) |=> lock);
endmodule

// File: rtl/pllcfg_top.sv
module pllcfg_top
    import pllcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic              pll_lock,
    output logic              pll_active,
    output logic              div_zero,
    output logic              div_bypass,
    output logic [DIV_W-1:0]  div_ratio,
    output logic [RAT_W-1:0]  mul_ratio,
    output logic              cfg_err
);
    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cfg.div = wr_data[DIV_LSB +: DIV_W];
            st_d.cfg.cnt = wr_data[CNT_LSB +: CNT_W];
            st_d.cfg.rng = wr_data[RNG_LSB +: RNG_W];
            st_d.cfg.mul = wr_data[MUL_LSB +: MUL_W];
            st_d.cfg.mrk = wr_data[MRK_BIT];
            if (!wr_data[MRK_BIT]) st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pllcfg_ratio_dec #(.DIV_W(DIV_W), .MUL_W(MUL_W)) u_dec (
        .div_f      (st_q.cfg.div),
        .mul_f      (st_q.cfg.mul),
        .div_ratio  (div_ratio),
        .mul_ratio  (mul_ratio),
        .active     (pll_active),
        .div_zero   (div_zero),
        .div_bypass (div_bypass)
    );

    pllcfg_lock_timer u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .restart   (wr_en),
        .run_ok    (pll_active && !div_zero),
        .load_val  (st_q.cfg.cnt),
        .lock      (pll_lock)
    );

    assign cfg_err = st_q.err;

    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            rd_data[0] = pll_lock;
            rd_data[1] = st_q.err;
            rd_data[2] = pll_active;
        end else begin
            rd_data[DIV_LSB +: DIV_W] = st_q.cfg.div;
            rd_data[CNT_LSB +: CNT_W] = st_q.cfg.cnt;
            rd_data[RNG_LSB +: RNG_W] = st_q.cfg.rng;
            rd_data[MUL_LSB +: MUL_W] = st_q.cfg.mul;
            rd_data[MRK_BIT]          = st_q.cfg.mrk;
        end
    end

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
    a_r8_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[MRK_BIT]) |=> cfg_err);
    a_r1_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.cfg));
endmodule

// File: tb/pllcfg_top_tb.sv
`timescale 1ns/1ps
module pllcfg_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        pll_lock, pll_active, div_zero, div_bypass, cfg_err;
    logic [7:0]  div_ratio;
    logic [11:0] mul_ratio;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pllcfg_top u_dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .pll_lock(pll_lock), .pll_active(pll_active), .div_zero(div_zero),
        .div_bypass(div_bypass), .div_ratio(div_ratio), .mul_ratio(mul_ratio),
        .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [31:0] w;
        logic [7:0]  ed;
        logic [11:0] em;
        logic        ea;
        logic        ez;
        logic        eb;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{32'h2000_0001, 8'd1,   12'd0,    1'b0, 1'b0, 1'b1},
        '{32'h2005_0000, 8'd0,   12'd6,    1'b1, 1'b1, 1'b0},
        '{32'h2007_4302, 8'd2,   12'd8,    1'b1, 1'b0, 1'b0},
        '{32'h27FF_FFFF, 8'd255, 12'd2048, 1'b1, 1'b0, 1'b0},
        '{32'h2001_8A10, 8'd16,  12'd2,    1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk); slow_tick = 1'b1;
        @(negedge clk); slow_tick = 1'b0;
    endtask

    function automatic logic [31:0] mk(input int dv, input int cn, input int ml);
        return 32'h2000_0000 | (32'(ml) << 16) | (32'(cn) << 8) | 32'(dv);
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_sel = 1'b0;
        #1 check("R9 config word", rd_data, 32'h0);
        rd_sel = 1'b1;
        #1 check("R9 status word", rd_data, 32'h0);
        rd_sel = 1'b0;

        // R1 R2 R3 vector table
        for (int i = 0; i < 5; i++) begin
            do_write(VEC[i].w);
            rd_sel = 1'b0;
            #1 check("R1 readback", rd_data, VEC[i].w);
            check("R2 div_ratio", {24'h0, div_ratio}, {24'h0, VEC[i].ed});
            check("R2 div flags", {30'h0, div_zero, div_bypass}, {30'h0, VEC[i].ez, VEC[i].eb});
            check("R3 mul_ratio", {20'h0, mul_ratio}, {20'h0, VEC[i].em});
            check("R3 active", {31'h0, pll_active}, {31'h0, VEC[i].ea});
        end

        // R4 count 3
        do_write(mk(4, 3, 9));
        check("R4 lock after write", {31'h0, pll_lock}, 32'h0);
        do_tick(); check("R4 tick1", {31'h0, pll_lock}, 32'h0);
        do_tick(); check("R4 tick2", {31'h0, pll_lock}, 32'h0);
        do_tick(); check("R4 tick3", {31'h0, pll_lock}, 32'h1);
        rd_sel = 1'b1;
        #1 check("R1 status lock", rd_data, 32'h5);
        rd_sel = 1'b0;
        // R10 hold
        do_tick(); do_tick();
        check("R10 lock holds", {31'h0, pll_lock}, 32'h1);
        // R6 identical rewrite
        do_write(mk(4, 3, 9));
        check("R6 cleared by rewrite", {31'h0, pll_lock}, 32'h0);
        do_tick(); do_tick();
        check("R6 restarted count", {31'h0, pll_lock}, 32'h0);
        // R6 rewrite mid-count with count 1
        do_write(mk(4, 1, 9));
        do_tick();
        check("R6 new count 1", {31'h0, pll_lock}, 32'h1);
        // R5 count 0
        do_write(mk(2, 0, 3));
        check("R5 before tick", {31'h0, pll_lock}, 32'h0);
        do_tick();
        check("R5 first tick", {31'h0, pll_lock}, 32'h1);
        // R7 multiplier 0
        do_write(mk(2, 1, 0));
        for (int k = 0; k < 4; k++) do_tick();
        check("R7 mul zero", {31'h0, pll_lock}, 32'h0);
        // R7 divider 0
        do_write(mk(0, 0, 5));
        for (int k = 0; k < 4; k++) do_tick();
        check("R7 div zero", {31'h0, pll_lock}, 32'h0);
        // R8 sticky error
        check("R8 clear before", {31'h0, cfg_err}, 32'h0);
        do_write(32'h0001_0102);
        check("R8 set", {31'h0, cfg_err}, 32'h1);
        rd_sel = 1'b0;
        #1 check("R1 marker readback", rd_data, 32'h0001_0102);
        do_write(mk(2, 1, 1));
        rd_sel = 1'b1;
        #1 check("R8 stays set", rd_data & 32'h2, 32'h2);
        rd_sel = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule